// File: doc/BRIEF.md
# Timer Compare Channel Bank

This block holds a small bank of output-compare channels that watch a free-running time counter supplied from outside. Each channel keeps a live compare value and one queued value. When the counter reaches or steps past the live value, the channel raises an event flag. It can then request an interrupt or a DMA transfer, and it drives its output pin as its mode selects. The queued value then becomes live on its own, so software can keep a steady pulse train going (for example one pulse per second) by writing one new compare value per event.

Software reaches each channel through a write port and a combinational read port. `wr_sel`/`rd_sel` = 0 selects the control/status register and 1 selects the compare register. Each channel runs a four-state machine:
- OFF: disabled, nothing loaded.
- LOADED: disabled, with a live compare value.
- WAIT: enabled, with no live value.
- ARMED: enabled, with a live value.

The transitions are:
- OFF goes to LOADED on a compare write, and to WAIT on a control write with a nonzero mode.
- LOADED goes to ARMED on a control write with a nonzero mode.
- WAIT goes to ARMED on a compare write.
- ARMED goes to WAIT on a match when no queued value and no compare write are present. On a match with a queued value it stays ARMED.
- WAIT or ARMED goes to OFF on a control write with mode 0.

Top module: `tcmp_bank`

## Requirements
- R1: After reset every control register reads 0, and every pin, flag, interrupt and DMA request output is low.
- R2: The control/status register has these fields: bit 7 event flag, bit 6 interrupt enable, bits [5:2] mode, bit 0 DMA request enable. Bit 1 reads 0. A compare-register read returns the live compare value.
- R3: A match occurs in ARMED when the live compare value lies in the window (previous counter, current counter], taken modulo 2^CNT_W. This covers landing exactly on the value, jumping past it, and crossing the counter wrap.
- R4: A match sets the event flag. A control write with bit 7 = 1 clears the flag, and a write with bit 7 = 0 leaves it unchanged. If a match and a clear fall in the same cycle, the match wins.
- R5: `irq_o[i]` is high exactly while the channel's flag and interrupt enable are both set. `dma_req_o[i]` is high exactly while the flag and DMA request enable are both set.
- R6: Mode 4'hF drives the pin high for exactly one cycle after each match.
- R7: Mode 4'h5 inverts the pin after each match.
- R8: Any other nonzero mode sets the flag on a match and leaves the pin unchanged.
- R9: When no value is live (OFF, WAIT), a compare write becomes the live value. In LOADED or ARMED a compare write replaces the queued value. At a match the queued value becomes live.
- R10: After a match with nothing queued, the live value stays, no further match fires, and the next compare write arms the channel directly.
- R11: A control write with mode 0 (including writing the whole register as 0) drives the pin low and stops all matches. It does not affect other channels.
- R12: `flags_o[i]` reports the event flag of channel i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CNT_W | Time counter value |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CH_W | Channel addressed by the write |
| wr_sel | input | 1 | 0 = control/status, 1 = compare |
| wr_data | input | DATA_W | Write data |
| rd_ch | input | CH_W | Channel addressed by the read |
| rd_sel | input | 1 | 0 = control/status, 1 = compare |
| rd_data | output | DATA_W | Read data, zero-extended |
| pin_o | output | NCH | Channel output pins |
| irq_o | output | NCH | Interrupt requests |
| dma_req_o | output | NCH | DMA requests |
| flags_o | output | NCH | Event flags of all channels |

## Verification
The bench builds the bank with NCH = 4, CNT_W = 16 and DATA_W = 32. With a 16-bit counter, a step from 16'hFFF0 to 16'h0010 takes the match window across the counter wrap in a single cycle. Four channels leave room to run the pulse, toggle, flag-only and disabled behaviours side by side, while checking that one channel's writes leave the others untouched.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

    typedef enum logic [1:0] {
        CH_OFF    = 2'd0,
        CH_LOADED = 2'd1,
        CH_WAIT   = 2'd2,
        CH_ARMED  = 2'd3
    } ch_state_e;

    localparam int unsigned CTL_W       = 8;
    localparam int unsigned CTL_DRE     = 0;
    localparam int unsigned CTL_MODE_LO = 2;
    localparam int unsigned CTL_MODE_HI = 5;
    localparam int unsigned CTL_IE      = 6;
    localparam int unsigned CTL_FLAG    = 7;
    localparam int unsigned MODE_W      = CTL_MODE_HI - CTL_MODE_LO + 1;

    localparam logic [MODE_W-1:0] MODE_OFF    = 4'h0;
    localparam logic [MODE_W-1:0] MODE_TOGGLE = 4'h5;
    localparam logic [MODE_W-1:0] MODE_PULSE  = 4'hF;

endpackage

// File: rtl/tcmp_window.sv
// Wrap-safe match window: hit when cmp lies in (prev, cur] modulo 2^CNT_W.
module tcmp_window #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prev_ok_i,
    input  logic [CNT_W-1:0] prev_i,
    input  logic [CNT_W-1:0] cur_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             hit_o
);

    logic [CNT_W-1:0] d_cmp;
    logic [CNT_W-1:0] d_cur;

    always_comb begin
        d_cmp = cmp_i - prev_i;
        d_cur = cur_i - prev_i;
        hit_o = prev_ok_i && (d_cmp != '0) && (d_cmp <= d_cur);
    end

    // R3: a counter that did not move cannot produce a match
    p_still_no_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_i == prev_i) |-> !hit_o);

endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel
    import tcmp_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_i,
    input  logic              ctl_we_i,
    input  logic              wr_clr_i,
    input  logic              wr_ie_i,
    input  logic [MODE_W-1:0] wr_mode_i,
    input  logic              wr_dre_i,
    input  logic              cmp_we_i,
    input  logic [CNT_W-1:0]  cmp_wdata_i,
    output logic [CNT_W-1:0]  act_cmp_o,
    output logic [CTL_W-1:0]  ctl_o,
    output logic              flag_o,
    output logic              irq_o,
    output logic              dma_o,
    output logic              pin_o
);

    ch_state_e         state_q, state_d;
    logic [CNT_W-1:0]  act_q, buf_q;
    logic              buf_v_q;
    logic [MODE_W-1:0] mode_q;
    logic              ie_q, dre_q, flag_q, pin_q;

    logic wr_on, wr_off, fire;

    assign wr_on  = ctl_we_i && (wr_mode_i != MODE_OFF);
    assign wr_off = ctl_we_i && (wr_mode_i == MODE_OFF);
    assign fire   = hit_i && (state_q == CH_ARMED);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (wr_on)         state_d = cmp_we_i ? CH_ARMED : CH_WAIT;
                else if (cmp_we_i) state_d = CH_LOADED;
            end
            CH_LOADED: begin
                if (wr_on)         state_d = CH_ARMED;
            end
            CH_WAIT: begin
                if (wr_off)        state_d = CH_OFF;
                else if (cmp_we_i) state_d = CH_ARMED;
            end
            CH_ARMED: begin
                if (wr_off)        state_d = CH_OFF;
                else if (fire && !buf_v_q && !cmp_we_i) state_d = CH_WAIT;
            end
            default:               state_d = CH_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q   <= '0;
            buf_q   <= '0;
            buf_v_q <= 1'b0;
            mode_q  <= MODE_OFF;
            ie_q    <= 1'b0;
            dre_q   <= 1'b0;
            flag_q  <= 1'b0;
            pin_q   <= 1'b0;
        end else begin
            // compare double buffer
            unique case (state_q)
                CH_OFF, CH_WAIT: begin
                    if (cmp_we_i) act_q <= cmp_wdata_i;
                end
                CH_LOADED: begin
                    if (cmp_we_i) begin
                        buf_q   <= cmp_wdata_i;
                        buf_v_q <= 1'b1;
                    end
                end
                CH_ARMED: begin
                    if (fire) begin
                        if (cmp_we_i)     act_q <= cmp_wdata_i;
                        else if (buf_v_q) act_q <= buf_q;
                        buf_v_q <= 1'b0;
                    end else if (cmp_we_i) begin
                        buf_q   <= cmp_wdata_i;
                        buf_v_q <= 1'b1;
                    end
                end
                default: ;
            endcase
            if (wr_off && (state_q == CH_WAIT || state_q == CH_ARMED))
                buf_v_q <= 1'b0;

            // control fields
            if (ctl_we_i) begin
                mode_q <= wr_mode_i;
                ie_q   <= wr_ie_i;
                dre_q  <= wr_dre_i;
            end

            // event flag: set wins over write-one-to-clear
            if (fire)                      flag_q <= 1'b1;
            else if (ctl_we_i && wr_clr_i) flag_q <= 1'b0;

            // output pin
            if (state_d == CH_OFF || state_d == CH_LOADED)
                pin_q <= 1'b0;
            else if (fire) begin
                if (mode_q == MODE_PULSE)       pin_q <= 1'b1;
                else if (mode_q == MODE_TOGGLE) pin_q <= ~pin_q;
            end else if (mode_q == MODE_PULSE)
                pin_q <= 1'b0;
        end
    end

    assign act_cmp_o = act_q;
    assign ctl_o     = {flag_q, ie_q, mode_q, 1'b0, dre_q};
    assign flag_o    = flag_q;
    assign irq_o     = flag_q & ie_q;
    assign dma_o     = flag_q & dre_q;
    assign pin_o     = pin_q;

    // R4: a match always leaves the flag set
    p_fire_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> flag_q);

    // R6: pulse lasts a single cycle
    p_pulse_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_q && mode_q == MODE_PULSE && !fire && !ctl_we_i) |=> !pin_q);

    // R7: toggle mode inverts the pin on each match
    p_toggle_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode_q == MODE_TOGGLE && !ctl_we_i) |=> (pin_q != $past(pin_q)));

    // R11: a disabled channel keeps its pin low
    p_off_pin_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_OFF || state_q == CH_LOADED) |-> !pin_q);

endmodule

// File: rtl/tcmp_bank.sv
module tcmp_bank
    import tcmp_pkg::*;
#(
    parameter int unsigned NCH    = 4,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CH_W-1:0]   rd_ch,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [NCH-1:0]    pin_o,
    output logic [NCH-1:0]    irq_o,
    output logic [NCH-1:0]    dma_req_o,
    output logic [NCH-1:0]    flags_o
);

    logic [CNT_W-1:0] prev_q;
    logic             prev_ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q    <= '0;
            prev_ok_q <= 1'b0;
        end else begin
            prev_q    <= cnt_i;
            prev_ok_q <= 1'b1;
        end
    end

    logic [CNT_W-1:0] act_arr [NCH];
    logic [CTL_W-1:0] ctl_arr [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel_ch, hit;

        assign sel_ch = wr_en && (wr_ch == CH_W'(i));

        tcmp_window #(.CNT_W(CNT_W)) u_win (
            .clk       (clk),
            .rst_n     (rst_n),
            .prev_ok_i (prev_ok_q),
            .prev_i    (prev_q),
            .cur_i     (cnt_i),
            .cmp_i     (act_arr[i]),
            .hit_o     (hit)
        );

        tcmp_channel #(.CNT_W(CNT_W)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .hit_i       (hit),
            .ctl_we_i    (sel_ch && !wr_sel),
            .wr_clr_i    (wr_data[CTL_FLAG]),
            .wr_ie_i     (wr_data[CTL_IE]),
            .wr_mode_i   (wr_data[CTL_MODE_HI:CTL_MODE_LO]),
            .wr_dre_i    (wr_data[CTL_DRE]),
            .cmp_we_i    (sel_ch && wr_sel),
            .cmp_wdata_i (wr_data[CNT_W-1:0]),
            .act_cmp_o   (act_arr[i]),
            .ctl_o       (ctl_arr[i]),
            .flag_o      (flags_o[i]),
            .irq_o       (irq_o[i]),
            .dma_o       (dma_req_o[i]),
            .pin_o       (pin_o[i])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_ch == CH_W'(i))
                rd_data = rd_sel ? DATA_W'(act_arr[i]) : DATA_W'(ctl_arr[i]);
        end
    end

    // R5: a request never appears without its flag
    p_irq_has_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~flags_o) == '0);
    p_dma_has_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req_o & ~flags_o) == '0);

endmodule

// File: tb/sim_tcmp_bank.sv
module sim_tcmp_bank;

    localparam int unsigned NCH = 4, CNT_W = 16, DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CNT_W-1:0]  cnt_i = '0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_ch = '0;
    logic              wr_sel = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [1:0]        rd_ch = '0;
    logic              rd_sel = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic [NCH-1:0]    pin_o, irq_o, dma_req_o, flags_o;

    always #2 clk = ~clk;

    tcmp_bank #(.NCH(NCH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i),
        .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data),
        .pin_o(pin_o), .irq_o(irq_o), .dma_req_o(dma_req_o), .flags_o(flags_o)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // {counter, clear flag this cycle, expected pin0, expected flag0}
    localparam logic [18:0] VEC [10] = '{
        {16'd30,  3'b000}, {16'd60,  3'b000}, {16'd90,  3'b000},
        {16'd120, 3'b011}, {16'd150, 3'b100}, {16'd180, 3'b000},
        {16'd210, 3'b011}, {16'd240, 3'b100}, {16'd300, 3'b000},
        {16'd400, 3'b000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step(input logic [15:0] v);
        cnt_i = v;
        tick();
    endtask

    task automatic wr(input int ch, input logic sel, input logic [31:0] d);
        wr_en = 1'b1; wr_ch = 2'(ch); wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input int ch, input logic sel, output logic [31:0] v);
        rd_ch = 2'(ch); rd_sel = sel;
        #1 v = rd_data;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int c = 0; c < NCH; c++) begin
            rd(c, 1'b0, v);
            chk("R1 ctrl reset", v, 32'h0);
        end
        chk("R1 pins", 32'(pin_o), 0);
        chk("R1 flags", 32'(flags_o), 0);
        chk("R1 irq/dma", 32'({irq_o, dma_req_o}), 0);

        // ch0: first value 100 while disabled, 200 queued, pulse + ie + dre
        wr(0, 1'b1, 100);
        wr(0, 1'b1, 200);
        rd(0, 1'b1, v);
        chk("R9 first write live", v, 100);
        wr(0, 1'b0, 32'h7D);
        rd(0, 1'b0, v);
        chk("R2 ctrl readback", v, 32'h7D);

        // table walk: R3 R4 R5 R6 R9 R10
        for (int k = 0; k < 10; k++) begin
            cnt_i = VEC[k][18:3];
            if (VEC[k][2]) begin
                wr_en = 1'b1; wr_ch = 2'd0; wr_sel = 1'b0; wr_data = 32'hFD;
            end
            tick();
            wr_en = 1'b0;
            chk($sformatf("R6 pin0 vec%0d", k), 32'(pin_o[0]), 32'(VEC[k][1]));
            chk($sformatf("R4 flag0 vec%0d", k), 32'(flags_o[0]), 32'(VEC[k][0]));
            chk($sformatf("R5 irq0 vec%0d", k), 32'(irq_o[0]), 32'(VEC[k][0]));
            chk($sformatf("R5 dma0 vec%0d", k), 32'(dma_req_o[0]), 32'(VEC[k][0]));
            if (k == 3) begin
                rd(0, 1'b1, v);
                chk("R9 queued value live after match", v, 200);
            end
        end

        // R10: re-arm directly after exhausting the queue
        wr(0, 1'b1, 420);
        rd(0, 1'b1, v);
        chk("R10 write arms live value", v, 420);
        step(430);
        chk("R10 rearmed pulse", 32'(pin_o[0]), 1);
        step(440);
        chk("R6 pulse ends", 32'(pin_o[0]), 0);
        wr(0, 1'b0, 32'hFD);
        chk("R4 write-one clears", 32'(flags_o[0]), 0);

        // ch1: toggle, exact landing
        wr(1, 1'b1, 500);
        wr(1, 1'b0, 32'h14);
        wr(1, 1'b1, 520);
        step(500);
        chk("R3 exact landing toggles", 32'(pin_o[1]), 1);
        chk("R4 flag1 set", 32'(flags_o[1]), 1);
        chk("R5 irq1 masked", 32'(irq_o[1]), 0);
        step(510);
        chk("R7 toggle holds", 32'(pin_o[1]), 1);
        wr(1, 1'b0, 32'h14);
        chk("R4 write-zero keeps flag", 32'(flags_o[1]), 1);
        step(520);
        chk("R7 second toggle", 32'(pin_o[1]), 0);
        chk("R12 flags vector", 32'(flags_o), 32'h2);

        // ch2: counter jumps past compare
        wr(2, 1'b1, 600);
        wr(2, 1'b0, 32'h3C);
        step(2000);
        chk("R3 step-over pulse", 32'(pin_o[2]), 1);
        chk("R5 dma2 disabled", 32'(dma_req_o[2]), 0);
        chk("R12 flags vector 2", 32'(flags_o), 32'h6);

        // ch3: flag-only mode across wrap
        wr(3, 1'b1, 5);
        wr(3, 1'b0, 32'h04);
        step(16'hFFF0);
        chk("R3 no early match", 32'(flags_o[3]), 0);
        step(16'h0010);
        chk("R3 wrap match", 32'(flags_o[3]), 1);
        chk("R8 pin untouched", 32'(pin_o[3]), 0);
        chk("R12 flags vector 3", 32'(flags_o), 32'hE);

        // R11: disable ch1
        wr(1, 1'b1, 16'h20);
        step(16'h30);
        chk("R11 pin1 high before off", 32'(pin_o[1]), 1);
        wr(1, 1'b0, 32'h00);
        chk("R11 off drives pin low", 32'(pin_o[1]), 0);
        rd(1, 1'b0, v);
        chk("R11 ctrl after zero write", v, 32'h80);
        wr(1, 1'b0, 32'h80);
        wr(1, 1'b1, 16'h40);
        step(16'h50);
        chk("R11 no match while off", 32'(flags_o[1]), 0);
        chk("R11 pin stays low", 32'(pin_o[1]), 0);
        chk("R11 other flags kept", 32'(flags_o), 32'hC);

        done = 1'b1;
        finish_run();
    end

endmodule